// File: doc/BRIEF.md
# Set-Associative Cache Controller with Run-Time Write Policy

The block sits between a processor word port and a word-wide backing memory. It keeps a set-associative store of lines whose set count, words per line and way count are parameters. A parameter picks the replacement scheme: random, least recently used or least frequently used. Software-visible configuration is one small write strobe that selects how stores are handled. There are three policies. Store-through without allocation sends every store to memory and never fills a line for it. Store-through with allocation fills the line first and then sends the store to memory. Copy-back keeps stores in the line and writes the whole line out only when it is evicted.

A processor request is a level on `cpu_valid` with address, direction and store data. The block answers with a one-cycle `cpu_ready` pulse, which carries load data. The memory side carries one word per beat, and only one request is in flight at a time. Requests are served straight from memory, without touching the line store, when caching is switched off or the address falls in an inclusive uncached window. Six running counters are kept: read and write hits, read and write misses, and memory words read and written. Hits and misses are brought out as totals. Set count, words per line and way count must be powers of two and at least two.

Top module: `wpc_cache`

## Requirements
- R1: Reset invalidates every line, zeroes all four counter outputs, holds `cpu_ready` low, and selects store-through without allocation (policy code 0).
- R2: When `cache_en` is low or the address lies within [UNC_LO, UNC_HI], the access makes exactly one memory word transfer. `mrd_cnt` or `mwr_cnt` rises by one, and neither `hit_cnt` nor `miss_cnt` changes.
- R3: A cached load that hits returns the stored word, adds one to `hit_cnt`, and causes no memory traffic. `cpu_ready` is high for exactly one cycle per request.
- R4: A cached load that misses fills a line. It reads every word of the line from line base + 4·i with i running from 0 upward, adds WORDS to `mrd_cnt` and one to `miss_cnt`, and returns the word fetched from memory.
- R5: Under either store-through policy (codes 0 and 1), every cached store writes its word to memory and adds one to `mwr_cnt`, and no line is ever marked dirty.
- R6: Under policy 0, a store that misses every way adds one to `miss_cnt` and writes only to memory. It fills nothing, evicts nothing and leaves the replacement state alone, so a later load of that address still misses.
- R7: Under policy 1, a store miss fills the line (WORDS reads), merges the store into it, and then writes the single word to memory.
- R8: Under copy-back (code 2), a store hit only marks the line dirty. Evicting a dirty line first writes its WORDS words to memory (`mwr_cnt` += WORDS) and then fills the new line.
- R9: A cycle with `cfg_we` high while idle loads `cfg_pol` as the policy. Code 3 is ignored and leaves the previous policy in force.
- R10: The victim is the lowest-numbered invalid way of the set. If every way is valid, least-recently-used replacement takes the way touched longest ago.
- R11: With least-frequently-used replacement, a freshly filled way starts with a use count of 0, and each hit on it adds one. The victim is the valid way with the smallest count, the lowest index winning ties.
- R12: `mem_addr`, `mem_we` and `mem_wdata` stay steady while `mem_req` is high and `mem_ack` has not yet arrived, and the next beat starts only after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Caching switched on; low sends every access to memory |
| cfg_we | input | 1 | Load write policy from `cfg_pol` |
| cfg_pol | input | 2 | 0 store-through no allocate, 1 store-through allocate, 2 copy-back, 3 ignored |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Byte address (low two bits ignored for memory) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_ready` |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Beat accepted; read data valid in this cycle |
| mem_rdata | input | DATA_W | Memory read data |
| hit_cnt | output | CNT_W | Read plus write hits |
| miss_cnt | output | CNT_W | Read plus write misses |
| mrd_cnt | output | CNT_W | Memory words read |
| mwr_cnt | output | CNT_W | Memory words written |

## Verification
A cached hit completes with `cpu_ready` two cycles after the request is accepted. Each memory beat adds two cycles with the bench's acknowledging memory, so fills, write-backs and through-stores push completion out by a number of cycles that depends on the path taken. The bench therefore never waits a fixed count. It holds each request until it sees the `cpu_ready` pulse on a falling edge, and there it samples the load data and all four counters, every one of which has settled by that edge. Memory contents are compared only between phases, when the port is quiet.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    POL_WT_NOALLOC = 2'd0,
    POL_WT_ALLOC   = 2'd1,
    POL_WB         = 2'd2
  } wpol_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_EVICT, S_FILL, S_MWR, S_MRD
  } cst_e;

  localparam int REPL_RANDOM = 0;
  localparam int REPL_LRU    = 1;
  localparam int REPL_LFU    = 2;

  // counter increment vector positions
  localparam int INC_RDHIT = 0;
  localparam int INC_WRHIT = 1;
  localparam int INC_RDMIS = 2;
  localparam int INC_WRMIS = 3;
  localparam int INC_MRD   = 4;
  localparam int INC_MWR   = 5;
  localparam int NUM_INC   = 6;
endpackage

// File: rtl/wpc_stats.sv
module wpc_stats #(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [wpc_pkg::NUM_INC-1:0] inc_i,
  output logic [CNT_W-1:0]            hit_o,
  output logic [CNT_W-1:0]            miss_o,
  output logic [CNT_W-1:0]            mrd_o,
  output logic [CNT_W-1:0]            mwr_o
);
  import wpc_pkg::*;

  logic [CNT_W-1:0] c_q [NUM_INC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_INC; i++) c_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_INC; i++)
        if (inc_i[i]) c_q[i] <= c_q[i] + 1'b1;
    end
  end

  assign hit_o  = c_q[INC_RDHIT] + c_q[INC_WRHIT];
  assign miss_o = c_q[INC_RDMIS] + c_q[INC_WRMIS];
  assign mrd_o  = c_q[INC_MRD];
  assign mwr_o  = c_q[INC_MWR];

  // R4
  mrd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mrd_o - $past(mrd_o)) <= CNT_W'(1));
  // R3
  hit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o - $past(hit_o)) <= CNT_W'(1));
endmodule

// File: rtl/wpc_victim.sv
module wpc_victim #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int REPL  = 1,
  parameter int CW    = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             fresh_i,
  output logic [WAY_W-1:0] victim_o
);
  import wpc_pkg::*;

  logic [WAY_W-1:0] pick;

  // an invalid way always wins, lowest index first
  always_comb begin
    victim_o = pick;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_o = WAY_W'(w);
  end

  generate
    if (REPL == REPL_LRU) begin : g_lru
      logic [WAY_W-1:0] age [SETS][WAYS];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) age[s][w] <= WAY_W'(w);
        end else if (touch_i) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way_i) age[set_i][w] <= '0;
            else if (age[set_i][w] < age[set_i][way_i])
              age[set_i][w] <= age[set_i][w] + 1'b1;
          end
        end
      end
      always_comb begin
        pick = '0;
        for (int w = 0; w < WAYS; w++)
          if (age[set_i][w] == WAY_W'(WAYS - 1)) pick = WAY_W'(w);
      end
      // R10
      lru_young_chk: assert property (@(posedge clk) disable iff (rst)
        (touch_i || fresh_i) && touch_i |=> age[$past(set_i)][$past(way_i)] == '0);
    end else if (REPL == REPL_LFU) begin : g_lfu
      logic [CW-1:0] use_q [SETS][WAYS];
      logic [CW-1:0] best;
      always_ff @(posedge clk) begin
        if (touch_i) begin
          if (fresh_i) use_q[set_i][way_i] <= '0;
          else if (use_q[set_i][way_i] != {CW{1'b1}})
            use_q[set_i][way_i] <= use_q[set_i][way_i] + 1'b1;
        end
      end
      always_comb begin
        pick = '0;
        best = use_q[set_i][0];
        for (int w = 1; w < WAYS; w++)
          if (use_q[set_i][w] < best) begin
            best = use_q[set_i][w];
            pick = WAY_W'(w);
          end
      end
      // R11
      lfu_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        touch_i && fresh_i |=> use_q[$past(set_i)][$past(way_i)] == '0);
    end else begin : g_rnd
      logic [7:0] lfsr;
      always_ff @(posedge clk) begin
        if (rst) lfsr <= 8'h5A;
        else     lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      assign pick = lfsr[WAY_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WORDS  = 2,
  parameter int WAYS   = 2,
  parameter int CNT_W  = 16,
  parameter int REPL   = wpc_pkg::REPL_LRU,
  parameter logic [ADDR_W-1:0] UNC_LO = 'h0000_F000,
  parameter logic [ADDR_W-1:0] UNC_HI = 'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_pol,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [CNT_W-1:0]  mrd_cnt,
  output logic [CNT_W-1:0]  mwr_cnt
);
  import wpc_pkg::*;

  localparam int WOFF_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SET_LO = 2 + WOFF_W;
  localparam int TAG_LO = SET_LO + SET_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;

  cst_e              st;
  wpol_e             pol_q;
  logic [ADDR_W-1:0] a_q;
  logic              we_q, rdy_q, refill_q;
  logic [DATA_W-1:0] wd_q, rdata_q;
  logic [WAY_W-1:0]  vway_q, hway, victim;
  logic [WOFF_W-1:0] beat_q;
  logic [TAG_W-1:0]  evtag_q;

  logic [TAG_W-1:0]  tag_r  [WAYS][SETS];
  logic [SETS-1:0]   val_r  [WAYS];
  logic [SETS-1:0]   dirty_r[WAYS];
  logic [DATA_W-1:0] data_r [WAYS][SETS*WORDS];

  logic [SET_W-1:0]  idx;
  logic [WOFF_W-1:0] wsel;
  logic [TAG_W-1:0]  tg;
  logic [WAYS-1:0]   hitv, setval;
  logic              hit_any, bypass, is_wb, last_beat, look_hit, look_miss;
  logic [NUM_INC-1:0] inc;

  assign idx  = a_q[SET_LO +: SET_W];
  assign wsel = a_q[2 +: WOFF_W];
  assign tg   = a_q[ADDR_W-1:TAG_LO];

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      assign setval[gw] = val_r[gw][idx];
      assign hitv[gw]   = val_r[gw][idx] && (tag_r[gw][idx] == tg);
    end
  endgenerate

  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitv[w]) hway = WAY_W'(w);
  end

  assign hit_any   = |hitv;
  assign bypass    = !cache_en || (a_q >= UNC_LO && a_q <= UNC_HI);
  assign is_wb     = (pol_q == POL_WB);
  assign last_beat = (beat_q == WOFF_W'(WORDS - 1));
  assign look_hit  = (st == S_LOOK) && !bypass && hit_any;
  assign look_miss = (st == S_LOOK) && !bypass && !hit_any;

  wpc_victim #(.SETS(SETS), .WAYS(WAYS), .REPL(REPL)) u_victim (
    .clk(clk), .rst(rst), .set_i(idx), .valid_i(setval),
    .touch_i(look_hit), .way_i(hway), .fresh_i(refill_q), .victim_o(victim)
  );

  always_comb begin
    inc            = '0;
    inc[INC_RDHIT] = look_hit && !we_q && !refill_q;
    inc[INC_WRHIT] = look_hit && we_q && !refill_q;
    inc[INC_RDMIS] = look_miss && !we_q;
    inc[INC_WRMIS] = look_miss && we_q;
    inc[INC_MRD]   = mem_ack && (st == S_FILL || st == S_MRD);
    inc[INC_MWR]   = mem_ack && (st == S_EVICT || st == S_MWR);
  end

  wpc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .inc_i(inc),
    .hit_o(hit_cnt), .miss_o(miss_cnt), .mrd_o(mrd_cnt), .mwr_o(mwr_cnt)
  );

  // memory port decode from registered state
  always_comb begin
    mem_req   = (st == S_EVICT) || (st == S_FILL) || (st == S_MWR) || (st == S_MRD);
    mem_we    = (st == S_EVICT) || (st == S_MWR);
    mem_wdata = wd_q;
    case (st)
      S_EVICT: begin
        mem_addr  = {evtag_q, idx, beat_q, 2'b00};
        mem_wdata = data_r[vway_q][{idx, beat_q}];
      end
      S_FILL:  mem_addr = {tg, idx, beat_q, 2'b00};
      default: mem_addr = {a_q[ADDR_W-1:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      pol_q    <= POL_WT_NOALLOC;
      rdy_q    <= 1'b0;
      refill_q <= 1'b0;
      beat_q   <= '0;
      for (int w = 0; w < WAYS; w++) begin
        val_r[w]   <= '0;
        dirty_r[w] <= '0;
      end
    end else begin
      rdy_q <= 1'b0;
      if (cfg_we && st == S_IDLE && cfg_pol != 2'd3) pol_q <= wpol_e'(cfg_pol);
      case (st)
        S_IDLE: if (cpu_valid && !rdy_q) begin
          a_q  <= cpu_addr;
          we_q <= cpu_we;
          wd_q <= cpu_wdata;
          st   <= S_LOOK;
        end
        S_LOOK: begin
          refill_q <= 1'b0;
          if (bypass) begin
            st <= we_q ? S_MWR : S_MRD;
          end else if (hit_any) begin
            if (we_q) begin
              data_r[hway][{idx, wsel}] <= wd_q;
              if (is_wb) dirty_r[hway][idx] <= 1'b1;
              st    <= is_wb ? S_IDLE : S_MWR;
              rdy_q <= is_wb;
            end else begin
              rdata_q <= data_r[hway][{idx, wsel}];
              rdy_q   <= 1'b1;
              st      <= S_IDLE;
            end
          end else if (we_q && pol_q == POL_WT_NOALLOC) begin
            st <= S_MWR;
          end else begin
            vway_q              <= victim;
            beat_q              <= '0;
            evtag_q             <= tag_r[victim][idx];
            val_r[victim][idx]  <= 1'b0;
            dirty_r[victim][idx] <= 1'b0;
            st <= (setval[victim] && dirty_r[victim][idx] && is_wb) ? S_EVICT : S_FILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) st <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          data_r[vway_q][{idx, beat_q}] <= mem_rdata;
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            val_r[vway_q][idx] <= 1'b1;
            tag_r[vway_q][idx] <= tg;
            refill_q           <= 1'b1;
            st                 <= S_LOOK;
          end
        end
        S_MWR: if (mem_ack) begin
          rdy_q <= 1'b1;
          st    <= S_IDLE;
        end
        S_MRD: if (mem_ack) begin
          rdata_q <= mem_rdata;
          rdy_q   <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = rdy_q;
  assign cpu_rdata = rdata_q;

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R3
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R8
  evict_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_EVICT) |-> (pol_q == POL_WB));
  // R6
  noalloc_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FILL) |-> !(we_q && pol_q == POL_WT_NOALLOC));
endmodule

// File: tb/tb_wpc_cache.sv
`timescale 1ns/1ps
module tb_mem #(
  parameter int N = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output int          viol
);
  logic [31:0] m [N];
  logic        pend;
  logic [31:0] a_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      pend <= 1'b0;
      viol <= 0;
      for (int i = 0; i < N; i++) m[i] <= 32'hA000_0000 + i;
    end else begin
      ack <= req && !ack;
      if (req && !ack) begin
        if (we) m[addr[8:2]] <= wdata;
        else    rdata <= m[addr[8:2]];
      end
      if (pend && (!req || addr != a_prev)) viol <= viol + 1;
      pend   <= req && !ack;
      a_prev <= addr;
    end
  end
endmodule

module tb_wpc_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        cache_en = 1'b1, cfg_we = 1'b0;
  logic [1:0]  cfg_pol = 2'd0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, mem_req, mem_we, mem_ack;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] hit_cnt, miss_cnt, mrd_cnt, mwr_cnt;
  int          viol;

  wpc_cache #(.UNC_LO(32'h100), .UNC_HI(32'h13F)) dut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .cfg_we(cfg_we), .cfg_pol(cfg_pol),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .mrd_cnt(mrd_cnt), .mwr_cnt(mwr_cnt)
  );
  tb_mem u_mem (.clk(clk), .rst(rst), .req(mem_req), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .ack(mem_ack), .rdata(mem_rdata), .viol(viol));

  // second instance for the frequency-based replacement variant
  logic        l_valid = 1'b0;
  logic        l_ready, l_req, l_we, l_ack;
  logic [31:0] l_addr = '0, l_rdata, l_maddr, l_mwdata, l_mrdata;
  logic [15:0] l_hit, l_miss, l_mrd, l_mwr;
  int          l_viol;

  wpc_cache #(.UNC_LO(32'h100), .UNC_HI(32'h13F), .REPL(wpc_pkg::REPL_LFU)) dut_lfu (
    .clk(clk), .rst(rst), .cache_en(1'b1), .cfg_we(1'b0), .cfg_pol(2'd0),
    .cpu_valid(l_valid), .cpu_we(1'b0), .cpu_addr(l_addr), .cpu_wdata(32'h0),
    .cpu_ready(l_ready), .cpu_rdata(l_rdata),
    .mem_req(l_req), .mem_we(l_we), .mem_addr(l_maddr), .mem_wdata(l_mwdata),
    .mem_ack(l_ack), .mem_rdata(l_mrdata),
    .hit_cnt(l_hit), .miss_cnt(l_miss), .mrd_cnt(l_mrd), .mwr_cnt(l_mwr)
  );
  tb_mem u_mem_l (.clk(clk), .rst(rst), .req(l_req), .we(l_we), .addr(l_maddr),
    .wdata(l_mwdata), .ack(l_ack), .rdata(l_mrdata), .viol(l_viol));

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  // reference model state
  bit          m_val   [4][2];
  bit          m_dirty [4][2];
  int          m_tag   [4][2];
  int          m_stamp [4][2];
  int          tick, m_pol;
  bit          en_m;
  logic [31:0] golden [128];
  int          e_hit, e_miss, e_mrd, e_mwr;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_counts(input string rq);
    chk(rq, "hit_cnt",  {16'h0, hit_cnt},  32'(e_hit));
    chk(rq, "miss_cnt", {16'h0, miss_cnt}, 32'(e_miss));
    chk(rq, "mrd_cnt",  {16'h0, mrd_cnt},  32'(e_mrd));
    chk(rq, "mwr_cnt",  {16'h0, mwr_cnt},  32'(e_mwr));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
        m_val[s][w] = 0; m_dirty[s][w] = 0; m_stamp[s][w] = 0; m_tag[s][w] = 0;
      end
    for (int i = 0; i < 128; i++) golden[i] = 32'hA000_0000 + i;
    tick = 0; m_pol = 0;
    e_hit = 0; e_miss = 0; e_mrd = 0; e_mwr = 0;
    // R1: counters zero and no completion pulse after reset
    chk_counts("R1");
    chk("R1", "cpu_ready", {31'h0, cpu_ready}, 32'h0);
  endtask

  task automatic set_pol(input int p);
    @(negedge clk);
    cfg_pol = 2'(p);
    cfg_we  = 1'b1;
    @(negedge clk);
    cfg_we  = 1'b0;
    if (p != 3) m_pol = p;
  endtask

  task automatic xfer(input logic [31:0] addr, input logic we,
                      input logic [31:0] wd, input string rq_in);
    string rq;
    int s, t, hw, v, wi, n;
    logic [31:0] exp_rd;
    wi = int'(addr[8:2]);
    s  = int'(addr[4:3]);
    t  = int'(addr >> 5);
    if (!en_m || (addr >= 32'h100 && addr <= 32'h13F)) begin
      rq = "R2";
      if (we) e_mwr++; else e_mrd++;
    end else begin
      hw = -1;
      for (int w = 0; w < 2; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
      if (hw >= 0) begin
        e_hit++;
        m_stamp[s][hw] = ++tick;
        if (we) begin
          rq = (m_pol == 2) ? "R8" : "R5";
          if (m_pol == 2) m_dirty[s][hw] = 1; else e_mwr++;
        end else rq = "R3";
      end else begin
        e_miss++;
        if (we && m_pol == 0) begin
          rq = "R6";
          e_mwr++;
        end else begin
          v = -1;
          for (int w = 1; w >= 0; w--) if (!m_val[s][w]) v = w;
          if (v < 0) begin
            rq = "R10";
            v = (m_stamp[s][0] <= m_stamp[s][1]) ? 0 : 1;
          end else rq = we ? ((m_pol == 1) ? "R7" : "R8") : "R4";
          if (m_val[s][v] && m_dirty[s][v] && m_pol == 2) begin
            e_mwr += 2;
            rq = "R8";
          end
          e_mrd += 2;
          m_val[s][v] = 1; m_tag[s][v] = t; m_dirty[s][v] = 0;
          m_stamp[s][v] = ++tick;
          if (we) begin
            if (m_pol == 2) m_dirty[s][v] = 1; else e_mwr++;
          end
        end
      end
    end
    if (we) golden[wi] = wd;
    exp_rd = golden[wi];
    if (rq_in != "") rq = rq_in;

    @(negedge clk);
    cpu_addr = addr; cpu_we = we; cpu_wdata = wd; cpu_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_ready && n < 200);
    cpu_valid = 1'b0;
    if (n >= 200) chk(rq, "completion", 32'h0, 32'h1);
    if (!we) chk(rq, "rdata", cpu_rdata, exp_rd);
    chk_counts(rq);
  endtask

  function automatic logic [31:0] rnd_addr();
    return 32'($urandom % 80) << 2;
  endfunction

  task automatic rnd_run(input int n);
    for (int i = 0; i < n; i++) xfer(rnd_addr(), 1'($urandom % 2), $urandom, "");
  endtask

  task automatic mem_match(input string rq);
    int bad;
    bad = 0;
    for (int i = 0; i < 128; i++) if (u_mem.m[i] !== golden[i]) bad++;
    chk(rq, "memory words differing from stores", 32'(bad), 32'h0);
  endtask

  task automatic lread(input logic [31:0] addr);
    int n;
    @(negedge clk);
    l_addr = addr; l_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!l_ready && n < 200);
    l_valid = 1'b0;
    if (n >= 200) chk("R11", "completion", 32'h0, 32'h1);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    en_m = 1'b1;

    // store-through, no allocation, left at its reset default
    do_reset();
    xfer(32'h0000_0020, 1'b1, 32'h1111_2222, "R1");  // default policy: miss, memory only
    xfer(32'h0000_0020, 1'b0, 32'h0, "R6");          // still a miss: nothing was allocated
    xfer(32'h0000_0024, 1'b0, 32'h0, "R3");          // neighbour word of the filled line
    xfer(32'h0000_0044, 1'b0, 32'h0, "R4");          // fresh line fill
    xfer(32'h0000_0044, 1'b1, 32'h3333_4444, "R5");  // store hit goes through
    rnd_run(250);
    mem_match("R5");

    // store-through with allocation; code 3 must be ignored
    do_reset();
    set_pol(1);
    set_pol(3);
    xfer(32'h0000_0088, 1'b1, 32'h5555_6666, "R9");  // fills only if policy is still 1
    xfer(32'h0000_008C, 1'b1, 32'h7777_8888, "R7");
    rnd_run(250);
    mem_match("R7");

    // caching switched off: everything is a single-word memory access
    do_reset();
    cache_en = 1'b0; en_m = 1'b0;
    rnd_run(120);
    mem_match("R2");
    cache_en = 1'b1; en_m = 1'b1;

    // copy-back
    do_reset();
    set_pol(2);
    xfer(32'h0000_0000, 1'b1, 32'hDEAD_0001, "R8");
    xfer(32'h0000_0000, 1'b1, 32'hDEAD_0002, "R8");  // hit: no memory traffic
    xfer(32'h0000_0020, 1'b0, 32'h0, "R10");         // second way of set 0
    xfer(32'h0000_0040, 1'b0, 32'h0, "R8");          // evicts the dirty line
    xfer(32'h0000_0120, 1'b1, 32'hCAFE_0001, "R2");  // uncached window
    rnd_run(300);
    for (int i = 0; i < 64; i++) xfer(32'(i) << 2, 1'b0, 32'h0, "");
    chk("R12", "protocol violations", 32'(viol), 32'h0);

    // frequency-based replacement on the second instance, set 0
    do_reset();
    lread(32'h000);                    // miss, way 0, count 0
    repeat (3) lread(32'h000);         // three hits
    lread(32'h020);                    // miss, way 1, count 0
    lread(32'h020);                    // hit
    lread(32'h040);                    // miss: way 1 has the smaller count
    lread(32'h000);                    // must still hit
    chk("R11", "lfu misses", {16'h0, l_miss}, 32'd3);
    chk("R11", "lfu hits",   {16'h0, l_hit},  32'd5);
    lread(32'h020);                    // was evicted
    chk("R11", "lfu evicted line misses", {16'h0, l_miss}, 32'd4);
    chk("R12", "lfu protocol violations", 32'(l_viol), 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule